// File: doc/BRIEF.md
# Read-Intensive Address Profiler

The profiler is a small, fully associative table that remembers the block addresses a cache controller has flagged as read-intensive. It holds no data. Its output steers a placement decision. On a read miss, the controller looks up the missing block's address. A hit tells the placement logic to allocate the block into a low-variation non-volatile way. On a read hit, the controller also looks up the address, and a hit marks that entry as most recently used.

Counter logic outside the block decides when a block has become read-intensive. It then presents the block's address on the insert port. An address that is already present is only refreshed. Otherwise the new address takes the lowest-numbered free entry. When no entry is free, it overwrites the least-recently-used one. Recency is kept as a full ordering over all entries.

Top module: `rdint_profiler`

## Requirements
- R1: After reset, every entry is invalid, so every lookup misses.
- R2: The lookup result `lkp_hit_o` is combinational and reflects the table contents as they stood before the current clock edge.
- R3: `place_low_o` is 1 exactly when a lookup with `lkp_kind_i`=0 (read miss) hits. A lookup with `lkp_kind_i`=1 (read hit) never raises it.
- R4: An inserted address hits on lookups from the first cycle after the insert edge.
- R5: Inserting an address that is already present creates no second copy. After address A is inserted twice and 15 other distinct addresses follow, all 16 addresses hit.
- R6: While any entry is invalid, an insert of a new address fills a free entry and evicts nothing.
- R7: When all entries are valid, an insert of a new address evicts the least-recently-used address and keeps all the others.
- R8: A hitting lookup with `lkp_kind_i`=1 makes that entry most recently used. A lookup with `lkp_kind_i`=0 leaves the recency order unchanged.
- R9: Inserting an address that is already present makes it most recently used.
- R10: When an insert and a lookup occur in the same cycle, only the insert updates recency. The lookup's refresh is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_kind_i | input | 1 | Lookup kind: 1 = read hit (refresh on match), 0 = read miss |
| lkp_addr_i | input | TAG_W | Block address to look up |
| lkp_hit_o | output | 1 | Lookup address is present |
| place_low_o | output | 1 | Read-miss lookup hit: allocate into a low-variation non-volatile way |
| ins_valid_i | input | 1 | Insert request |
| ins_addr_i | input | TAG_W | Block address to insert |

## Verification
The lookup result and the placement flag are due in the same cycle as the request. The bench therefore checks them one time unit after driving the inputs and before the rising edge. Inserts and recency refreshes take effect at the next rising edge. After each operation, the bench waits one time unit past that edge. It then sweeps read-miss lookups across a 24-address universe. These lookups leave the state unchanged, and each result is compared with a recency-ordered list model kept in the bench. Evictions therefore show up as misses on exactly the address the model predicts.

// File: rtl/rip_pkg.sv
package rip_pkg;
  typedef enum logic {
    LK_RD_MISS = 1'b0,
    LK_RD_HIT  = 1'b1
  } lkp_kind_e;
endpackage

// File: rtl/rip_match.sv
module rip_match #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ENTRIES-1:0]              valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0]   tag_i,
  input  logic [TAG_W-1:0]                addr_i,
  output logic [ENTRIES-1:0]              match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == addr_i);
  end

  // duplicates would give multiple matches
  p_unique_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o));
endmodule

// File: rtl/rip_lru.sv
module rip_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // age 0 = most recent, ENTRIES-1 = least recent; ages form a permutation
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [ENTRIES-1:0]            is_old;
  logic [IDX_W-1:0]              ref_age;

  assign ref_age = age_q[touch_idx_i];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (IDX_W'(g) == touch_idx_i)  age_q[g] <= '0;
        else if (age_q[g] < ref_age)   age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign is_old[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (is_old[i]) lru_idx_o = IDX_W'(i);
  end

  p_single_lru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_old) == 1);

  p_touch_mru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/rip_slot_sel.sv
module rip_slot_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] match_i,
  input  logic [IDX_W-1:0]   lru_idx_i,
  output logic [IDX_W-1:0]   slot_o
);
  // priority: existing copy, then lowest free entry, then LRU victim
  always_comb begin
    slot_o = lru_idx_i;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) slot_o = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (match_i[i]) slot_o = IDX_W'(i);
  end
endmodule

// File: rtl/rdint_profiler.sv
module rdint_profiler
  import rip_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic             lkp_kind_i,
  input  logic [TAG_W-1:0] lkp_addr_i,
  output logic             lkp_hit_o,
  output logic             place_low_o,
  input  logic             ins_valid_i,
  input  logic [TAG_W-1:0] ins_addr_i
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            lkp_match, ins_match;
  logic [IDX_W-1:0]              lkp_idx, ins_slot, lru_idx, touch_idx;
  logic                          touch_en, ins_hit;

  rip_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lkp_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .tag_i(tag_q),
    .addr_i(lkp_addr_i), .match_o(lkp_match));

  rip_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ins_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .tag_i(tag_q),
    .addr_i(ins_addr_i), .match_o(ins_match));

  rip_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i, .rst_ni, .touch_i(touch_en), .touch_idx_i(touch_idx),
    .lru_idx_o(lru_idx));

  rip_slot_sel #(.ENTRIES(ENTRIES)) u_slot (
    .valid_i(valid_q), .match_i(ins_match), .lru_idx_i(lru_idx),
    .slot_o(ins_slot));

  always_comb begin
    lkp_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lkp_match[i]) lkp_idx = IDX_W'(i);
  end

  assign ins_hit     = |ins_match;
  assign lkp_hit_o   = lkp_valid_i && (|lkp_match);
  assign place_low_o = lkp_hit_o && (lkp_kind_e'(lkp_kind_i) == LK_RD_MISS);

  // insert owns the recency update when both ports fire
  assign touch_en  = ins_valid_i ||
                     (lkp_hit_o && (lkp_kind_e'(lkp_kind_i) == LK_RD_HIT));
  assign touch_idx = ins_valid_i ? ins_slot : lkp_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (ins_valid_i) begin
      valid_q[ins_slot] <= 1'b1;
      tag_q[ins_slot]   <= ins_addr_i;
    end
  end

  p_insert_stored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |=> valid_q[$past(ins_slot)] &&
                    tag_q[$past(ins_slot)] == $past(ins_addr_i));

  p_free_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !ins_hit && !(&valid_q)) |=>
      $countones(valid_q) == $past($countones(valid_q)) + 1);

  p_reinsert_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_hit) |=> $stable(valid_q) && $stable(tag_q));

  p_hit_kind_no_place_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_kind_i) |-> !place_low_o);
endmodule

// File: tb/sim_rdint_profiler.sv
module sim_rdint_profiler;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int TW    = 20;
  localparam int UNIV  = 24;

  logic clk = 0, rst_n = 0;
  logic lkp_valid = 0, lkp_kind = 0, ins_valid = 0;
  logic [TW-1:0] lkp_addr = '0, ins_addr = '0;
  logic lkp_hit, place_low;
  int n_chk = 0, n_fail = 0;
  logic [TW-1:0] lst[$];   // index 0 = most recently used
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  rdint_profiler #(.ENTRIES(N), .TAG_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lkp_valid_i(lkp_valid), .lkp_kind_i(lkp_kind),
    .lkp_addr_i(lkp_addr), .lkp_hit_o(lkp_hit), .place_low_o(place_low),
    .ins_valid_i(ins_valid), .ins_addr_i(ins_addr));

  function automatic logic [TW-1:0] univ(int u);
    return TW'(32'h0AB00 + u * 32'h1111);
  endfunction

  function automatic int mfind(logic [TW-1:0] a);
    for (int i = 0; i < lst.size(); i++) if (lst[i] == a) return i;
    return -1;
  endfunction

  function automatic void mtouch(logic [TW-1:0] a);
    int k;
    k = mfind(a);
    if (k >= 0) lst.delete(k);
    lst.push_front(a);
  endfunction

  function automatic void minsert(logic [TW-1:0] a);
    if (mfind(a) < 0 && lst.size() == N) void'(lst.pop_back());
    mtouch(a);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // read-miss lookups do not change state; sweep the whole universe
  task automatic probe_all(string req);
    lkp_valid = 1; lkp_kind = 0;
    for (int u = 0; u < UNIV; u++) begin
      lkp_addr = univ(u);
      #1;
      check(req, lkp_hit, mfind(univ(u)) >= 0, $sformatf("hit addr %0d", u));
      check(req, place_low, mfind(univ(u)) >= 0, $sformatf("place addr %0d", u));
    end
    lkp_valid = 0;
  endtask

  task automatic step(bit do_ins, int ia, bit do_lkp, int la, bit kind, string req);
    bit exp_hit;
    @(negedge clk);
    ins_valid = do_ins; ins_addr = univ(ia);
    lkp_valid = do_lkp; lkp_addr = univ(la); lkp_kind = kind;
    #1;
    if (do_lkp) begin
      exp_hit = mfind(univ(la)) >= 0;
      check("R2", lkp_hit, exp_hit, "same-cycle lookup");
      check("R3", place_low, exp_hit && !kind, "placement flag");
    end
    @(posedge clk); #1;
    ins_valid = 0; lkp_valid = 0;
    if (do_ins) minsert(univ(ia));
    else if (do_lkp && kind && mfind(univ(la)) >= 0) mtouch(univ(la));
    probe_all(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    probe_all("R1");
    step(1, 0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, 0, "R5");
    for (int u = 1; u < N; u++) step(1, u, 0, 0, 0, "R6");
    probe_all("R5");
    step(0, 0, 1, 0, 1, "R8");    // refresh entry 0
    step(0, 0, 1, 1, 0, "R8");    // read-miss lookup must not refresh entry 1
    step(1, 16, 0, 0, 0, "R7");   // entry 1 is now the victim
    step(1, 2, 0, 0, 0, "R9");    // refresh 2 by re-insert
    step(1, 17, 1, 3, 1, "R10");  // 3 not refreshed, so it is evicted
    step(1, 18, 0, 0, 0, "R7");
    for (int s = 0; s < 300; s++) begin
      int op, a, b;
      string req;
      seed = seed * 32'd1103515245 + 32'd12345;
      op = int'(seed[31:30]); a = int'(seed[23:16]) % UNIV; b = int'(seed[15:8]) % UNIV;
      case (op)
        0: begin
          if (mfind(univ(a)) >= 0) req = "R9";
          else if (lst.size() < N) req = "R6";
          else req = "R7";
          step(1, a, 0, 0, 0, req);
        end
        1: step(0, 0, 1, b, 1, "R8");
        2: step(1, a, 1, b, 1, "R10");
        default: step(0, 0, 1, b, 0, "R3");
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule